// File: doc/BRIEF.md
# Inter-Processor Mailbox with Per-User Interrupts

This peripheral lets several processors exchange 32-bit words through a set of independent hardware message queues. A processor posts a word by writing a queue's message register and takes the oldest word by reading the same register. Per-queue registers report whether a queue is full and how many words it holds.

Each processor (a "user") has its own event status register, an enable-set register and an enable-clear register. Every queue contributes two event bits to every user: one meaning "holds at least one message" and one meaning "has room for another message". A user's interrupt line is high while any event that user has enabled is pending. A user typically enables the message event of the queue it listens on, and the room event of a queue it is waiting to write.

Access is through a simple register bus: word address, write enable, read enable, write data and registered read data. The build has four queues, three users and four entries per queue.

Top module: `mbox_hub`

## Requirements
- R1: While reset is held and after it is released, every enable mask is zero and every interrupt line is low. Address 0x000 reads back the REVISION parameter, and a write to it has no effect.
- R2: A write to offset 0x040 + 4*m appends the write data to queue m. A read of the same offset removes and returns the oldest word, so words leave in the order they entered.
- R3: A write to a queue that holds DEPTH words is dropped. A read of an empty queue returns zero and changes no state.
- R4: Offset 0x080 + 4*m reads 1 while queue m holds DEPTH words, and reads 0 otherwise.
- R5: Offset 0x0C0 + 4*m reads the number of words queue m holds. Zero means the queue is empty.
- R6: In user u's status register at 0x104 + 0x10*u, bit 2*m is set in every cycle after one in which queue m held a word. Bit 2*m+1 is set in every cycle after one in which queue m held fewer than DEPTH words. Set bits stay set until cleared.
- R7: Writing ones to a status register clears those bits, and zero bits leave bits unchanged. If the event condition still holds, the set wins and the bit stays set.
- R8: A write to 0x108 + 0x10*u sets the enable bits given as ones. A write to 0x10C + 0x10*u clears the enable bits given as ones. Reading either address returns user u's enable mask. Enable bits use the same positions as the status bits.
- R9: irq[u] is high exactly while user u's status AND enable is nonzero. It follows the registers in the same cycle.
- R10: Status writes, enable writes and interrupts of one user leave every other user's registers and interrupt unaffected.
- R11: Read data is valid in the cycle after rd_en and is zero in the cycle after any cycle without rd_en. Unmapped addresses read zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW (9) | Byte address of the register |
| wr_en | input | 1 | Write strobe; never together with rd_en |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq | output | NUSERS (3) | One interrupt line per user |

## Verification
The bench builds the block with its defaults: four queues, three users and a depth of four. It overrides only the revision value, so that the read-back is a distinctive pattern. A depth of four lets the bench reach a full queue with five writes, which covers the dropped write, the full flag and the room event that returns after one read. Three users are enough to show that one user's enables and clears leave the others untouched. All eight event bits of each user are exercised through the behavioural model on every clock.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_REV,
        ACC_MSG,
        ACC_FULL,
        ACC_CNT,
        ACC_STAT,
        ACC_ENSET,
        ACC_ENCLR
    } acc_kind_e;

    localparam int unsigned BASE_MSG   = 32'h040;
    localparam int unsigned BASE_FULL  = 32'h080;
    localparam int unsigned BASE_CNT   = 32'h0C0;
    localparam int unsigned BASE_USER  = 32'h104;
    localparam int unsigned USER_PITCH = 32'h010;
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
    import mbox_pkg::*;
#(
    parameter int NQ  = 4,
    parameter int NU  = 3,
    parameter int AW  = 9,
    localparam int QIW = (NQ > 1) ? $clog2(NQ) : 1,
    localparam int UIW = (NU > 1) ? $clog2(NU) : 1
) (
    input  logic [AW-1:0]  addr,
    output acc_kind_e      kind,
    output logic [QIW-1:0] qsel,
    output logic [UIW-1:0] usel
);
    always_comb begin
        kind = ACC_NONE;
        qsel = '0;
        usel = '0;
        if (addr == '0) kind = ACC_REV;
        for (int m = 0; m < NQ; m++) begin
            if (addr == AW'(BASE_MSG + 4*m)) begin
                kind = ACC_MSG;  qsel = QIW'(m);
            end
            if (addr == AW'(BASE_FULL + 4*m)) begin
                kind = ACC_FULL; qsel = QIW'(m);
            end
            if (addr == AW'(BASE_CNT + 4*m)) begin
                kind = ACC_CNT;  qsel = QIW'(m);
            end
        end
        for (int u = 0; u < NU; u++) begin
            if (addr == AW'(BASE_USER + USER_PITCH*u)) begin
                kind = ACC_STAT;  usel = UIW'(u);
            end
            if (addr == AW'(BASE_USER + USER_PITCH*u + 4)) begin
                kind = ACC_ENSET; usel = UIW'(u);
            end
            if (addr == AW'(BASE_USER + USER_PITCH*u + 8)) begin
                kind = ACC_ENCLR; usel = UIW'(u);
            end
        end
    end
endmodule

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && (count != '0);
    assign head    = (count != '0) ? mem[rptr] : '0;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> $stable(count));
    // R3
    empty_pop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && count == '0) |-> (head == '0));
endmodule

// File: rtl/mbox_user_irq.sv
module mbox_user_irq #(
    parameter int NB = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] cond,
    input  logic          wr_stat,
    input  logic          wr_set,
    input  logic          wr_clr,
    input  logic [NB-1:0] wbits,
    output logic [NB-1:0] status,
    output logic [NB-1:0] enable,
    output logic          irq
);
    logic [NB-1:0] stat_clr, en_set, en_clr;

    assign stat_clr = wr_stat ? wbits : '0;
    assign en_set   = wr_set  ? wbits : '0;
    assign en_clr   = wr_clr  ? wbits : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            enable <= '0;
        end else begin
            status <= (status & ~stat_clr) | cond;
            enable <= (enable | en_set) & ~en_clr;
        end
    end

    assign irq = |(status & enable);

    // R7
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> ((status & $past(wbits & ~cond)) == '0));
    // R8
    enable_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set && !wr_clr) |=> ((enable & $past(wbits)) == $past(wbits)));
    // R8
    enable_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((enable & $past(wbits)) == '0));
endmodule

// File: rtl/mbox_hub.sv
module mbox_hub
    import mbox_pkg::*;
#(
    parameter int          NQUEUES  = 4,
    parameter int          NUSERS   = 3,
    parameter int          DEPTH    = 4,
    parameter int          AW       = 9,
    parameter logic [31:0] REVISION = 32'h0001_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [NUSERS-1:0] irq
);
    localparam int DW  = 32;
    localparam int NB  = 2 * NQUEUES;
    localparam int CW  = $clog2(DEPTH + 1);
    localparam int QIW = (NQUEUES > 1) ? $clog2(NQUEUES) : 1;
    localparam int UIW = (NUSERS > 1) ? $clog2(NUSERS) : 1;

    acc_kind_e      kind;
    logic [QIW-1:0] qsel;
    logic [UIW-1:0] usel;
    logic [DW-1:0]  qhead [NQUEUES];
    logic [CW-1:0]  qcnt  [NQUEUES];
    logic [NQUEUES-1:0] qfull;
    logic [NB-1:0]  cond;
    logic [NB-1:0]  ustat [NUSERS];
    logic [NB-1:0]  uen   [NUSERS];
    logic [DW-1:0]  rd_value;

    mbox_decode #(.NQ(NQUEUES), .NU(NUSERS), .AW(AW)) u_decode (
        .addr(addr), .kind(kind), .qsel(qsel), .usel(usel)
    );

    for (genvar m = 0; m < NQUEUES; m++) begin : g_queue
        logic hit;
        assign hit = (kind == ACC_MSG) && (qsel == QIW'(m));
        mbox_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
            .clk(clk), .rst_n(rst_n),
            .push(wr_en && hit), .pop(rd_en && hit),
            .wdata(wdata), .head(qhead[m]), .count(qcnt[m]), .full(qfull[m])
        );
        assign cond[2*m]     = (qcnt[m] != '0);
        assign cond[2*m + 1] = !qfull[m];
    end

    for (genvar u = 0; u < NUSERS; u++) begin : g_user
        logic mine;
        assign mine = wr_en && (usel == UIW'(u));
        mbox_user_irq #(.NB(NB)) u_irq (
            .clk(clk), .rst_n(rst_n), .cond(cond),
            .wr_stat(mine && kind == ACC_STAT),
            .wr_set(mine && kind == ACC_ENSET),
            .wr_clr(mine && kind == ACC_ENCLR),
            .wbits(wdata[NB-1:0]),
            .status(ustat[u]), .enable(uen[u]), .irq(irq[u])
        );
        for (genvar m = 0; m < NQUEUES; m++) begin : g_evt
            // R6
            msg_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (qcnt[m] != '0) |=> ustat[u][2*m]);
            // R6
            room_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !qfull[m] |=> ustat[u][2*m + 1]);
        end
    end

    always_comb begin
        unique case (kind)
            ACC_REV:   rd_value = REVISION;
            ACC_MSG:   rd_value = qhead[qsel];
            ACC_FULL:  rd_value = DW'(qfull[qsel]);
            ACC_CNT:   rd_value = DW'(qcnt[qsel]);
            ACC_STAT:  rd_value = DW'(ustat[usel]);
            ACC_ENSET,
            ACC_ENCLR: rd_value = DW'(uen[usel]);
            default:   rd_value = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd_en ? rd_value : '0;
    end

    // R11
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == '0));
endmodule

// File: tb/test_mbox_hub.sv
module test_mbox_hub;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] REV = 32'h5A01_0002;
    localparam int NQ = 4, NU = 3, DEPTH = 4;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [8:0]  addr = '0;
    logic        wr_en = 0, rd_en = 0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  irq;

    int checks = 0, failures = 0;
    bit done = 0;

    int unsigned mq [NQ][$];
    logic [7:0]  mst [NU];
    logic [7:0]  men [NU];

    mbox_hub #(.REVISION(REV)) i_mbox_hub (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int qof(input logic [8:0] a, input int base);
        for (int m = 0; m < NQ; m++) if (a == 9'(base + 4*m)) return m;
        return -1;
    endfunction
    function automatic int uof(input logic [8:0] a, input int off);
        for (int u = 0; u < NU; u++) if (a == 9'(32'h104 + 16*u + off)) return u;
        return -1;
    endfunction

    function automatic logic [31:0] model_read(input logic [8:0] a);
        int i;
        if (a == 0) return REV;
        i = qof(a, 32'h040); if (i >= 0) return (mq[i].size() != 0) ? mq[i][0] : 0;
        i = qof(a, 32'h080); if (i >= 0) return (mq[i].size() == DEPTH) ? 1 : 0;
        i = qof(a, 32'h0C0); if (i >= 0) return mq[i].size();
        i = uof(a, 0); if (i >= 0) return {24'b0, mst[i]};
        i = uof(a, 4); if (i >= 0) return {24'b0, men[i]};
        i = uof(a, 8); if (i >= 0) return {24'b0, men[i]};
        return 0;
    endfunction

    task automatic model_update(input logic w, input logic r, input logic [8:0] a, input logic [31:0] d);
        logic [7:0] c;
        int i;
        for (int m = 0; m < NQ; m++) begin
            c[2*m]   = mq[m].size() != 0;
            c[2*m+1] = mq[m].size() < DEPTH;
        end
        for (int u = 0; u < NU; u++) begin
            if (w && uof(a, 0) == u) mst[u] = mst[u] & ~d[7:0];
            mst[u] = mst[u] | c;
            if (w && uof(a, 4) == u) men[u] = men[u] | d[7:0];
            if (w && uof(a, 8) == u) men[u] = men[u] & ~d[7:0];
        end
        i = qof(a, 32'h040);
        if (i >= 0) begin
            if (w && mq[i].size() < DEPTH) mq[i].push_back(d);
            if (r && mq[i].size() != 0) void'(mq[i].pop_front());
        end
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input logic w, input logic r, input logic [8:0] a,
                       input logic [31:0] d, input string tag);
        logic [31:0] exp;
        logic [2:0]  eirq;
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d;
        @(posedge clk);
        exp = r ? model_read(a) : 32'h0;
        model_update(w, r, a, d);
        for (int u = 0; u < NU; u++) eirq[u] = |(mst[u] & men[u]);
        #1;
        check(irq === eirq, "R9", "irq", {29'b0, irq}, {29'b0, eirq});
        check(rdata === exp, r ? tag : "R11", "rdata", rdata, exp);
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d, input string tag);
        cyc(1, 0, a, d, tag);
    endtask
    task automatic rd(input logic [8:0] a, input string tag);
        cyc(0, 1, a, 0, tag);
    endtask
    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, "R9");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(irq === 3'b0, "R1", "irq in reset", {29'b0, irq}, 0);
        check(rdata === 32'h0, "R1", "rdata in reset", rdata, 0);
        @(negedge clk); rst_n = 1;
        idle(2);
        // R1 revision and its write immunity; enables zero after reset
        rd(9'h000, "R1");
        wr(9'h000, 32'hFFFF_FFFF, "R1");
        rd(9'h000, "R1");
        rd(9'h108, "R1");
        // R5 / R4 empty queues
        for (int m = 0; m < NQ; m++) rd(9'(32'h0C0 + 4*m), "R5");
        for (int m = 0; m < NQ; m++) rd(9'(32'h080 + 4*m), "R4");
        // R8 enable set and readback through both enable addresses
        wr(9'h108, 32'h1, "R8");
        rd(9'h108, "R8");
        rd(9'h10C, "R8");
        // R2 pushes, irq0 on new message (R9)
        wr(9'h040, 32'h0000_00A1, "R2");
        wr(9'h040, 32'h0000_00A2, "R2");
        idle(1);
        rd(9'h0C0, "R5");
        rd(9'h104, "R6");
        // R7 clear while message present has no lasting effect
        wr(9'h104, 32'h1, "R7");
        rd(9'h104, "R7");
        // R2 order
        rd(9'h040, "R2");
        rd(9'h040, "R2");
        // R3 empty pop
        rd(9'h040, "R3");
        rd(9'h0C0, "R3");
        // R7 clear now sticks
        wr(9'h104, 32'h1, "R7");
        idle(1);
        rd(9'h104, "R7");
        // R3 overflow on queue 1
        for (int k = 0; k < 5; k++) wr(9'h044, 32'hB000_0000 + k, "R3");
        rd(9'h0C4, "R3");
        rd(9'h084, "R4");
        // R10 user 1 room event on queue 1 (bit 3); user 2 untouched
        wr(9'h118, 32'h8, "R10");
        wr(9'h114, 32'h8, "R7");
        idle(1);
        rd(9'h114, "R7");
        rd(9'h044, "R2");
        idle(2);
        rd(9'h114, "R6");
        rd(9'h128, "R10");
        rd(9'h124, "R10");
        // R8 enable clear drops irq1
        wr(9'h11C, 32'h8, "R8");
        rd(9'h118, "R8");
        // R11 unmapped
        wr(9'h1F0, 32'hDEAD_BEEF, "R11");
        rd(9'h1F0, "R11");
        rd(9'h100, "R11");
        // drain queue 1
        for (int k = 0; k < 4; k++) rd(9'h044, "R2");
        // R10 user 2 enables everything, mixed traffic on queues 2 and 3
        wr(9'h128, 32'hFF, "R10");
        for (int k = 0; k < 24; k++) begin
            int q;
            q = 2 + (k % 2);
            if ((k % 5) < 3) wr(9'(32'h040 + 4*q), 32'h1234_0000 + k*7, "R2");
            else             rd(9'(32'h040 + 4*q), "R2");
            if (k % 4 == 0) wr(9'h124, 32'(k * 37) & 32'hFF, "R7");
            if (k % 6 == 0) rd(9'(32'h0C0 + 4*q), "R5");
            if (k % 7 == 0) rd(9'h124, "R6");
        end
        for (int k = 0; k < 6; k++) begin
            rd(9'h048, "R2");
            rd(9'h04C, "R2");
        end
        wr(9'h12C, 32'hFF, "R8");
        idle(3);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule